// File: doc/BRIEF.md
# Oversampled Serial Receive/Transmit Engine

This block moves bytes over a two-wire asynchronous serial link, one wire per direction. All of its timing is counted in pulses of an oversampling enable that an external prescaler supplies; the system clock only moves the registers. The number of pulses per bit is chosen at run time: sixteen, or eight for a faster link on the same enable.

The receiver watches the idle-high input for a low level. It then confirms the start bit with one more sample at the middle of the bit. A short low glitch fails this check and is dropped without any error. After a confirmed start, the receiver takes one sample at the middle of each data bit and one at the middle of the stop bit. It then presents the byte with a one-cycle strobe, together with a flag that reports a bad stop bit.

The transmitter takes a byte through a valid/ready handshake and shifts out a complete frame. The frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The client may flip the ratio select at any time. The block only takes in a new ratio while neither direction is busy, so a frame in flight keeps the bit length it started with.

Top module: `os_uart_core`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle: `tx_out` high, `tx_ready` high, `rx_valid` and `rx_ferr` low, and the ratio set to sixteen pulses per bit.
- R2: While the receiver is idle, a clock edge with `os_tick` high and `rx_in` low starts a possible character. That edge is not counted as a pulse of the character.
- R3: The start bit is checked again on the half-bit pulse after detection: the 8th pulse at ratio sixteen, the 4th at ratio eight. If `rx_in` is high there, the receiver goes back to idle with no strobe and no error.
- R4: After a confirmed start, data bits are sampled one bit time apart (16 or 8 pulses), and the first sample lands one bit time after the confirmation. The first sample is bit 0 of `rx_data`. One bit time after the eighth data sample, the stop bit is sampled, and in the next cycle `rx_valid` is high for exactly one cycle with the byte on `rx_data`.
- R5: `rx_ferr` is high in the `rx_valid` cycle exactly when the stop sample was low, and it is low in every other cycle.
- R6: The edge that accepts a byte drives `tx_out` low for the start bit. Then bits 0 to 7 of the byte follow, then a high stop bit. Each of the ten bits lasts exactly one bit time of pulses, and afterwards the line is high.
- R7: `tx_ready` is high exactly when the transmitter is idle. A byte is taken at an edge where `tx_valid` and `tx_ready` are both high, and `tx_valid` has no effect while `tx_ready` is low.
- R8: `mode_x8` = 0 selects sixteen pulses per bit and a half bit of eight. `mode_x8` = 1 selects eight pulses per bit and a half bit of four.
- R9: The ratio is taken from `mode_x8` only at edges where both the receiver and the transmitter are idle. A change during a character does not alter that character's timing.
- R10: Without an `os_tick` pulse, neither direction advances: a bit never ends, and no sample is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, one pulse per sample slot |
| mode_x8 | input | 1 | Ratio select: 0 = 16 pulses per bit, 1 = 8 |
| rx_in | input | 1 | Serial receive line, idles high |
| tx_out | output | 1 | Serial transmit line, idles high |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle, can take a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_ferr | output | 1 | Stop bit sampled low, valid with `rx_valid` |

## Verification
The bench sends bytes with alternating bits, single set bits at both ends of the byte, and mixed values. It uses an enable pulse on every clock and also sparser pulses, so that a design counting clocks instead of pulses gives itself away. A low stop bit separates a design that flags framing errors from one that ignores the stop sample. Low glitches shorter than half a bit, at each ratio, separate a mid-bit start check from a plain edge trigger. The ratio select is flipped in the middle of a transmitted frame, and the frame must keep its starting length. A send and a receive run at the same time to show that the two directions do not disturb each other.

// File: rtl/osu_pkg.sv
package osu_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_CONFIRM,
    RX_DATA,
    RX_STOP
  } rx_phase_e;

  // Pulses per bit for the selected ratio
  function automatic int unsigned ticks_per_bit(input logic fast,
                                                input int unsigned hi,
                                                input int unsigned lo);
    return fast ? lo : hi;
  endfunction

  // Pulses from start detection to the mid-bit confirmation sample
  function automatic int unsigned ticks_to_mid(input logic fast,
                                               input int unsigned hi,
                                               input int unsigned lo);
    return ticks_per_bit(fast, hi, lo) / 2;
  endfunction

endpackage

// File: rtl/osu_rx.sv
module osu_rx #(
  parameter int unsigned OSR_HI = 16,
  parameter int unsigned OSR_LO = 8,
  parameter int unsigned DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          fast,
  input  logic          rx_in,
  output logic          rx_busy,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_ferr
);
  import osu_pkg::*;

  localparam int unsigned CW = $clog2(OSR_HI);
  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

  rx_phase_e     phase;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] shreg;
  logic [CW-1:0] lim_full;
  logic [CW-1:0] lim_half;

  // Named internal events
  logic start_seen;
  logic mid_hit;
  logic confirm_fail;
  logic bit_hit;
  logic stop_sample;

  always_comb begin
    lim_full = CW'(ticks_per_bit(fast, OSR_HI, OSR_LO) - 1);
    lim_half = CW'(ticks_to_mid(fast, OSR_HI, OSR_LO) - 1);
  end

  assign start_seen   = (phase == RX_IDLE) && os_tick && !rx_in;
  assign mid_hit      = (phase == RX_CONFIRM) && os_tick && (cnt == lim_half);
  assign confirm_fail = mid_hit && rx_in;
  assign bit_hit      = ((phase == RX_DATA) || (phase == RX_STOP)) && os_tick && (cnt == lim_full);
  assign stop_sample  = bit_hit && (phase == RX_STOP);
  assign rx_busy      = (phase != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
      unique case (phase)
        RX_IDLE: begin
          if (start_seen) begin
            phase <= RX_CONFIRM;
            cnt   <= '0;
          end
        end
        RX_CONFIRM: begin
          if (mid_hit) begin
            cnt <= '0;
            idx <= '0;
            phase <= rx_in ? RX_IDLE : RX_DATA;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_hit) begin
            cnt   <= '0;
            shreg <= {rx_in, shreg[DW-1:1]};
            if (idx == IW'(DW - 1)) phase <= RX_STOP;
            else                    idx   <= idx + 1'b1;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (stop_sample) begin
            cnt      <= '0;
            phase    <= RX_IDLE;
            rx_data  <= shreg;
            rx_valid <= 1'b1;
            rx_ferr  <= !rx_in;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= RX_IDLE;
      endcase
    end
  end

  // R3: a failed confirmation returns to idle and reports nothing
  p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
    confirm_fail |=> (!rx_valid && !rx_busy));

  // R4: the byte strobe lasts one cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5: the error flag only appears with the strobe
  p_ferr_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ferr |-> rx_valid);

  // R10: nothing moves without a pulse
  p_rx_wait_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !os_tick |=> ($stable(rx_busy) && !rx_valid));

endmodule

// File: rtl/osu_tx.sv
module osu_tx #(
  parameter int unsigned OSR_HI = 16,
  parameter int unsigned OSR_LO = 8,
  parameter int unsigned DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          fast,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tx_out,
  output logic          tx_busy
);
  import osu_pkg::*;

  localparam int unsigned CW = $clog2(OSR_HI);
  localparam int unsigned LW = $clog2(DW + 2);

  logic [CW-1:0] cnt;
  logic [LW-1:0] left;
  logic [DW:0]   frame;
  logic [CW-1:0] lim_full;

  // Named internal events
  logic accept;
  logic bit_end;

  always_comb lim_full = CW'(ticks_per_bit(fast, OSR_HI, OSR_LO) - 1);

  assign tx_ready = !tx_busy;
  assign accept   = tx_valid && tx_ready;
  assign bit_end  = tx_busy && os_tick && (cnt == lim_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0;
      tx_out  <= 1'b1;
      frame   <= '1;
      left    <= '0;
      cnt     <= '0;
    end else if (accept) begin
      tx_busy <= 1'b1;
      tx_out  <= 1'b0;
      frame   <= {1'b1, tx_data};
      left    <= LW'(DW + 1);
      cnt     <= '0;
    end else if (bit_end) begin
      cnt <= '0;
      if (left == '0) begin
        tx_busy <= 1'b0;
        tx_out  <= 1'b1;
      end else begin
        tx_out <= frame[0];
        frame  <= {1'b1, frame[DW:1]};
        left   <= left - 1'b1;
      end
    end else if (tx_busy && os_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: an idle transmitter leaves the line high
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> tx_out);

  // R6: an accepted byte begins with a low start bit
  p_start_low_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!tx_out && !tx_ready));

  // R10: the line holds without a pulse
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!os_tick && !accept) |=> $stable(tx_out));

endmodule

// File: rtl/os_uart_core.sv
module os_uart_core #(
  parameter int unsigned OSR_HI = 16,
  parameter int unsigned OSR_LO = 8,
  parameter int unsigned DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          mode_x8,
  input  logic          rx_in,
  output logic          tx_out,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_ferr
);

  logic mode_q;
  logic tx_busy;
  logic rx_busy;
  logic both_idle;

  assign both_idle = !tx_busy && !rx_busy;

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= 1'b0;
    else if (both_idle) mode_q <= mode_x8;
  end

  osu_rx #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO), .DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .os_tick  (os_tick),
    .fast     (mode_q),
    .rx_in    (rx_in),
    .rx_busy  (rx_busy),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr)
  );

  osu_tx #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO), .DW(DW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .os_tick  (os_tick),
    .fast     (mode_q),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_out   (tx_out),
    .tx_busy  (tx_busy)
  );

  // R9: the ratio is frozen while either direction works
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_busy || rx_busy) |=> $stable(mode_q));

endmodule

// File: tb/os_uart_core_tb.sv
module os_uart_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       mode_x8 = 1'b0;
  logic       rx_in = 1'b1;
  logic       tx_out;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ferr;

  int compared = 0;
  int mismatched = 0;
  int tick_div = 1;
  int tick_ctr = 0;
  int cycles = 0;
  int tx_ticks = 0;
  logic [7:0] got_q[$];
  bit         gotf_q[$];

  always #4 clk = ~clk;

  os_uart_core u_dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .mode_x8(mode_x8),
    .rx_in(rx_in), .tx_out(tx_out), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
  );

  // Pulse generator: one pulse every tick_div clocks
  always @(negedge clk) begin
    if (tick_ctr + 1 >= tick_div) tick_ctr <= 0;
    else tick_ctr <= tick_ctr + 1;
    os_tick <= (tick_ctr == 0);
  end

  // Behavioural reference model
  bit        m_fast;
  bit        m_tx_act, m_rx_act;
  int        m_tx_t, m_rx_t;
  bit [9:0]  m_tx_frame;
  bit        m_tx_out;
  bit [7:0]  m_rx_byte, m_rx_dout;
  bit        m_rx_valid, m_rx_ferr;

  always @(posedge clk) begin
    int len, half, k;
    if (rst) begin
      m_fast = 0; m_tx_act = 0; m_rx_act = 0; m_tx_out = 1;
      m_rx_valid = 0; m_rx_ferr = 0; m_rx_dout = 0; m_tx_t = 0; m_rx_t = 0;
    end else begin
      if (!m_tx_act && !m_rx_act) m_fast = mode_x8;
      len = m_fast ? 8 : 16;
      half = len / 2;
      m_rx_valid = 0;
      m_rx_ferr = 0;
      if (m_tx_act) begin
        if (os_tick) begin
          m_tx_t++;
          if (m_tx_t == 10 * len) m_tx_act = 0;
        end
      end else if (tx_valid) begin
        m_tx_act = 1;
        m_tx_t = 0;
        m_tx_frame = {1'b1, tx_data, 1'b0};
      end
      m_tx_out = m_tx_act ? m_tx_frame[m_tx_t / len] : 1'b1;
      if (!m_rx_act) begin
        if (os_tick && !rx_in) begin
          m_rx_act = 1;
          m_rx_t = 0;
        end
      end else if (os_tick) begin
        m_rx_t++;
        if (m_rx_t == half) begin
          if (rx_in) m_rx_act = 0;
        end else if (m_rx_t > half && ((m_rx_t - half) % len) == 0) begin
          k = (m_rx_t - half) / len;
          if (k <= 8) m_rx_byte[k-1] = rx_in;
          else begin
            m_rx_valid = 1;
            m_rx_ferr = !rx_in;
            m_rx_dout = m_rx_byte;
            m_rx_act = 0;
          end
        end
      end
    end
    if (!rst && !tx_ready && os_tick) tx_ticks++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R6", "tx_out", tx_out, m_tx_out);
      check("R7", "tx_ready", tx_ready, !m_tx_act);
      check("R4", "rx_valid", rx_valid, m_rx_valid);
      check("R5", "rx_ferr", rx_ferr, m_rx_ferr);
      if (m_rx_valid) check("R4", "rx_data", rx_data, m_rx_dout);
      if (rx_valid) begin
        got_q.push_back(rx_data);
        gotf_q.push_back(rx_ferr);
      end
    end
  end

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (os_tick) c++;
    end
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop_bit, input bit fast);
    int len = fast ? 8 : 16;
    rx_in = 1'b0;
    wait_ticks(len);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      wait_ticks(len);
    end
    rx_in = stop_bit;
    wait_ticks(len);
    rx_in = 1'b1;
    wait_ticks(3);
  endtask

  task automatic glitch_rx(input int n, input bit fast);
    rx_in = 1'b0;
    wait_ticks(n);
    rx_in = 1'b1;
    wait_ticks(fast ? 12 : 24);
  endtask

  task automatic send_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check("R7", "tx_ready after accept", tx_ready, 0);
    check("R6", "start bit", tx_out, 0);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic expect_rx(input string req, input logic [7:0] b, input bit ferr);
    check(req, "byte count", got_q.size(), 1);
    if (got_q.size() > 0) begin
      check(req, "rx byte", got_q.pop_front(), b);
      check("R5", "rx ferr", gotf_q.pop_front(), ferr);
    end
    got_q.delete();
    gotf_q.delete();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "tx_out reset", tx_out, 1);
    check("R1", "tx_ready reset", tx_ready, 1);
    check("R1", "rx_valid reset", rx_valid, 0);
    check("R1", "rx_ferr reset", rx_ferr, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 R4 R6: x16, a pulse every clock, both directions together
    fork
      send_rx(8'hA5, 1'b1, 1'b0);
      send_tx(8'h3C);
    join
    expect_rx("R4", 8'hA5, 0);

    // R10: sparse pulses, edge bits of the byte
    tick_div = 3;
    send_rx(8'h01, 1'b1, 1'b0);
    expect_rx("R10", 8'h01, 0);
    send_rx(8'h80, 1'b1, 1'b0);
    expect_rx("R2", 8'h80, 0);
    tx_ticks = 0;
    send_tx(8'h96);
    check("R10", "tx frame pulses x16", tx_ticks, 160);

    // R5: low stop bit
    send_rx(8'h5A, 1'b0, 1'b0);
    expect_rx("R5", 8'h5A, 1);

    // R3: glitch shorter than half a bit at x16
    glitch_rx(6, 1'b0);
    check("R3", "no byte after glitch x16", got_q.size(), 0);

    // R8: ratio eight
    mode_x8 = 1'b1;
    tick_div = 2;
    repeat (4) @(negedge clk);
    fork
      send_rx(8'h5A, 1'b1, 1'b1);
      send_tx(8'hC3);
    join
    expect_rx("R8", 8'h5A, 0);
    tx_ticks = 0;
    send_tx(8'h0F);
    check("R8", "tx frame pulses x8", tx_ticks, 80);
    glitch_rx(3, 1'b1);
    check("R3", "no byte after glitch x8", got_q.size(), 0);

    // R9: flip ratio mid-frame
    mode_x8 = 1'b0;
    repeat (4) @(negedge clk);
    tx_ticks = 0;
    fork
      send_tx(8'h6B);
      begin
        repeat (40) @(negedge clk);
        mode_x8 = 1'b1;
      end
    join
    check("R9", "tx frame keeps x16", tx_ticks, 160);
    mode_x8 = 1'b0;
    repeat (4) @(negedge clk);
    fork
      send_rx(8'hE7, 1'b1, 1'b0);
      begin
        wait_ticks(30);
        mode_x8 = 1'b1;
      end
    join
    expect_rx("R9", 8'hE7, 0);

    // R1: reset mid-frame
    @(negedge clk);
    tx_data = 8'h00;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "tx_out after reset", tx_out, 1);
    check("R1", "tx_ready after reset", tx_ready, 1);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule